// File: doc/BRIEF.md
# Bus-Mapped Bidirectional Port Controller

This peripheral sits on a small parallel host bus. The bus has an 8-bit address, a shared 8-bit data line and two active-low strobes, one for reads and one for writes. Behind the bus are six 8-bit bidirectional pin groups. The direction of each group applies to the whole group and is held in one of two three-bit direction registers. Each group also has an output register, and the group drives that value onto its pins only while it is set as an output.

A host read of a group's address returns the levels on the group's pins. For an input group these are the levels from outside; for an output group they are the block's own value. A read of a direction register returns its bits. The block drives the data line only during a read of a mapped address and releases it at all other times. The write strobe is synchronized to the clock, and each write strobe loads a register once.

Top module: `gpio_tri_ctrl`

## Requirements
- R1: After reset all six direction bits are 0, so every group is an input and its pins are released, and every output register holds 0x00.
- R2: Address 0xF3 is the direction register for groups 0, 1 and 2. Bit 0 selects group 0, bit 1 group 1 and bit 2 group 2. A 1 makes the group an output and a 0 makes it an input.
- R3: Address 0xF7 is the direction register for groups 3, 4 and 5, with bit 0, bit 1 and bit 2 selecting groups 3, 4 and 5 in that order.
- R4: A write to a group address loads that group's output register. The group addresses are 0xF0, 0xF1 and 0xF2 for groups 0 to 2, and 0xF4, 0xF5 and 0xF6 for groups 3 to 5.
- R5: A read of a group address returns the present level on that group's pins.
- R6: A group drives its output register value only while its direction bit is 1. The output register can be written while the group is an input, and the stored value appears on the pins once the group becomes an output.
- R7: A read of a direction register returns the register in bits 2:0, with bits 7:3 read as 0. Written bits 7:3 are discarded.
- R8: The data line is driven only while the read strobe is low and the address is one of 0xF0 to 0xF7. At all other times it is released.
- R9: A write takes effect once per write strobe, on the synchronized falling edge. A change of the data value later in the same strobe does not change the register.
- R10: A write to an address outside 0xF0 to 0xF7 changes no register.
- R11: A write strobe that begins and ends while reset is asserted leaves every register at its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Host address |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_data | inout | 8 | Shared host data line |
| gpio | inout | 48 | Six 8-bit pin groups; group n occupies bits 8n+7:8n |

## Verification
Two functions can land in the same cycle here. One is a write strobe edge, which loads a register. The other is reset, which clears the same registers. The bench asserts reset, runs a complete write strobe to the direction register while reset is still low, and releases reset only after the strobe has ended. After that it reads the direction register back and reads a group, and a correct block returns zeros from both. A second case overlaps a register load with a data change inside one strobe. The bench changes the data value halfway through a write, and the readback must show the value that was present at the strobe edge.

// File: rtl/gpio_tri_pkg.sv
package gpio_tri_pkg;

  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NPORT   = 6;
  localparam int unsigned GRP_SZ  = 3;
  localparam int unsigned NGRP    = NPORT / GRP_SZ;
  localparam int unsigned SEL_W   = 3;
  localparam logic [ADDR_W-1:0] WIN_BASE = 8'hF0;

  typedef struct packed {
    logic             hit;
    logic             is_dir;
    logic             grp;
    logic [SEL_W-1:0] port;
  } dec_t;

  // Eight-entry window: slots 3 and 7 hold direction, others map to ports.
  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t r;
    logic [SEL_W-1:0] slot;
    slot     = a[SEL_W-1:0];
    r.hit    = (a[ADDR_W-1:SEL_W] == WIN_BASE[ADDR_W-1:SEL_W]);
    r.is_dir = (slot == 3'd3) || (slot == 3'd7);
    r.grp    = slot[2];
    r.port   = slot[2] ? (slot - 3'd1) : slot;
    return r;
  endfunction

endpackage

// File: rtl/gpio_tri_rstsync.sv
module gpio_tri_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_tri_edge.sv
module gpio_tri_edge #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic low
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], strobe_n};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign low  = ~sync_q[SYNC-1];
  assign fall = prev_q & ~sync_q[SYNC-1];
endmodule

// File: rtl/gpio_tri_regs.sv
module gpio_tri_regs
  import gpio_tri_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_fall,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NPORT-1:0]                  dir_q,
  output logic [NPORT-1:0][DATA_W-1:0]      out_q
);
  dec_t                          dec;
  logic [NPORT-1:0]              dir_d;
  logic [NPORT-1:0][DATA_W-1:0]  out_d;

  always_comb begin
    dec   = decode(addr);
    dir_d = dir_q;
    out_d = out_q;
    if (dec.hit) begin
      if (dec.is_dir)
        dir_d[int'(dec.grp)*GRP_SZ +: GRP_SZ] = wdata[GRP_SZ-1:0];
      else
        out_d[dec.port] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_fall) begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/gpio_tri_rdmux.sv
module gpio_tri_rdmux
  import gpio_tri_pkg::*;
(
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         rd_n,
  input  logic [NPORT-1:0]             dir_q,
  input  logic [NPORT-1:0][DATA_W-1:0] pin_lvl,
  output logic [DATA_W-1:0]            rd_val,
  output logic                         rd_oe
);
  dec_t dec;

  always_comb begin
    dec    = decode(addr);
    rd_oe  = ~rd_n & dec.hit;
    rd_val = '0;
    if (dec.is_dir)
      rd_val[GRP_SZ-1:0] = dir_q[int'(dec.grp)*GRP_SZ +: GRP_SZ];
    else
      rd_val = pin_lvl[dec.port];
  end
endmodule

// File: rtl/gpio_tri_ctrl.sv
module gpio_tri_ctrl
  import gpio_tri_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rd_n,
  input  logic                      bus_wr_n,
  inout  wire  [DATA_W-1:0]         bus_data,
  inout  wire  [NPORT*DATA_W-1:0]   gpio
);
  logic                         rst_q;
  logic                         wr_fall;
  logic                         wr_low;
  logic [NPORT-1:0]             dir_q;
  logic [NPORT-1:0][DATA_W-1:0] out_q;
  logic [NPORT-1:0][DATA_W-1:0] pin_lvl;
  logic [DATA_W-1:0]            rd_val;
  logic                         rd_oe;

  gpio_tri_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  gpio_tri_edge #(.SYNC(2)) u_wr (
    .clk(clk), .rst_n(rst_q), .strobe_n(bus_wr_n),
    .fall(wr_fall), .low(wr_low)
  );

  gpio_tri_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr_fall(wr_fall),
    .addr(bus_addr), .wdata(bus_data),
    .dir_q(dir_q), .out_q(out_q)
  );

  gpio_tri_rdmux u_rd (
    .addr(bus_addr), .rd_n(bus_rd_n), .dir_q(dir_q),
    .pin_lvl(pin_lvl), .rd_val(rd_val), .rd_oe(rd_oe)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_pad
    assign gpio[i*DATA_W +: DATA_W] = dir_q[i] ? out_q[i] : {DATA_W{1'bz}};
    assign pin_lvl[i]               = gpio[i*DATA_W +: DATA_W];
  end

  assign bus_data = rd_oe ? rd_val : {DATA_W{1'bz}};
endmodule

// File: rtl/gpio_tri_ctrl_chk.sv
module gpio_tri_ctrl_chk
  import gpio_tri_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rst_q,
  input logic                      bus_rd_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      wr_fall,
  input logic                      wr_low,
  input logic [NPORT-1:0]          dir_q,
  input logic [NPORT*DATA_W-1:0]   out_flat,
  input logic                      rd_oe,
  input logic [DATA_W-1:0]         rd_val
);
  logic in_window;
  assign in_window = (bus_addr >= WIN_BASE) && (bus_addr <= WIN_BASE + 8'd7);

  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_q)
    rd_oe |-> (!bus_rd_n && in_window));

  assert_dir_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_oe && bus_addr[1:0] == 2'b11) |-> (rd_val[DATA_W-1:GRP_SZ] == '0));

  assert_change_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_q)
    ((dir_q != $past(dir_q)) || (out_flat != $past(out_flat))) |-> $past(wr_fall));

  assert_one_edge_per_strobe_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_low && $past(wr_low)) |-> !wr_fall);

  assert_change_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_q)
    ((dir_q != $past(dir_q)) || (out_flat != $past(out_flat))) |-> $past(in_window));

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (dir_q == '0 && out_flat == '0));
endmodule

bind gpio_tri_ctrl gpio_tri_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q(rst_q), .bus_rd_n(bus_rd_n),
  .bus_addr(bus_addr), .wr_fall(wr_fall), .wr_low(wr_low),
  .dir_q(dir_q), .out_flat(out_q), .rd_oe(rd_oe), .rd_val(rd_val)
);

// File: tb/gpio_tri_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_tri_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  addr;
  logic        rd_n;
  logic        wr_n;
  logic        drv_en;
  logic [7:0]  drv_val;
  logic [5:0]  dir_m;
  logic [5:0][7:0] ext_val;
  wire  [7:0]  data;
  wire  [47:0] gpio;
  int          checks;
  int          errs;
  bit          done;

  gpio_tri_ctrl u_gpio_tri_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .bus_data(data), .gpio(gpio)
  );

  assign data = drv_en ? drv_val : 8'hzz;
  for (genvar i = 0; i < 6; i++) begin : g_ext
    assign gpio[i*8 +: 8] = dir_m[i] ? 8'hzz : ext_val[i];
  end

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [7:0]  d;
    logic [7:0]  e;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hF3, 8'h00, 8'h00, "R1"},
    '{1'b1, 8'hF7, 8'h00, 8'h00, "R1"},
    '{1'b1, 8'hF0, 8'h00, 8'h00, "R1"},
    '{1'b1, 8'hF1, 8'h00, 8'h38, "R5"},
    '{1'b0, 8'hF0, 8'hAA, 8'h00, "R4"},
    '{1'b1, 8'hF0, 8'h00, 8'h00, "R6"},
    '{1'b0, 8'hF3, 8'h05, 8'h00, "R2"},
    '{1'b1, 8'hF3, 8'h00, 8'h05, "R2"},
    '{1'b1, 8'hF0, 8'h00, 8'hAA, "R6"},
    '{1'b0, 8'hF7, 8'hFA, 8'h00, "R7"},
    '{1'b1, 8'hF7, 8'h00, 8'h02, "R7"},
    '{1'b0, 8'hF2, 8'hBB, 8'h00, "R4"},
    '{1'b1, 8'hF2, 8'h00, 8'hBB, "R4"},
    '{1'b0, 8'hF5, 8'hCC, 8'h00, "R3"},
    '{1'b1, 8'hF5, 8'h00, 8'hCC, "R3"},
    '{1'b1, 8'hF4, 8'h00, 8'h55, "R3"},
    '{1'b1, 8'hF6, 8'h00, 8'h68, "R5"},
    '{1'b0, 8'hF1, 8'h77, 8'h00, "R6"},
    '{1'b1, 8'hF1, 8'h00, 8'h38, "R6"},
    '{1'b0, 8'hF3, 8'h07, 8'h00, "R6"},
    '{1'b1, 8'hF1, 8'h00, 8'h77, "R6"},
    '{1'b0, 8'hF3, 8'h05, 8'h00, "R2"},
    '{1'b0, 8'hF8, 8'h11, 8'h00, "R10"},
    '{1'b0, 8'h70, 8'h22, 8'h00, "R10"},
    '{1'b1, 8'hF0, 8'h00, 8'hAA, "R10"},
    '{1'b1, 8'hF3, 8'h00, 8'h05, "R10"},
    '{1'b1, 8'hF2, 8'h00, 8'hBB, "R10"}
  };

  task automatic check(input logic [31:0] tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model of the direction registers, from R2, R3 and R7.
  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hF3) dir_m[2:0] = d[2:0];
    if (a == 8'hF7) dir_m[5:3] = d[2:0];
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; drv_val = d; drv_en = 1'b1;
    repeat (6) @(negedge clk);
    wr_n = 1'b0;
    repeat (10) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    drv_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; drv_en = 1'b0;
    repeat (6) @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    v = data;
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    checks = 0; errs = 0; done = 1'b0;
    rst_n = 1'b0; addr = 8'h00; rd_n = 1'b1; wr_n = 1'b1;
    drv_en = 1'b0; drv_val = 8'h00; dir_m = '0;
    ext_val = '{8'h68, 8'h00, 8'h55, 8'h00, 8'h38, 8'h00};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_read(VEC[i].a, v);
        check(VEC[i].tag, v, VEC[i].e);
      end else begin
        bus_write(VEC[i].a, VEC[i].d);
      end
    end

    // R8: read strobe high at a mapped address, bus must stay released
    @(negedge clk);
    addr = 8'hF0; drv_val = 8'h00; drv_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", data, 8'h00);
    // R8: strobe low at unmapped 0x70 (low bits alias group 0, which holds 0xAA)
    addr = 8'h70;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", data, 8'h00);
    rd_n = 1'b1; drv_en = 1'b0;
    repeat (4) @(negedge clk);

    // R9: data change halfway through one strobe
    @(negedge clk);
    addr = 8'hF2; drv_val = 8'h11; drv_en = 1'b1;
    repeat (6) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    drv_val = 8'h22;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    drv_en = 1'b0;
    bus_read(8'hF2, v);
    check("R9", v, 8'h11);

    // R11: full write strobe while reset is asserted
    @(negedge clk);
    rst_n = 1'b0; dir_m = '0;
    addr = 8'hF3; drv_val = 8'h07; drv_en = 1'b1;
    repeat (3) @(negedge clk);
    wr_n = 1'b0;
    repeat (10) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    drv_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(8'hF3, v);
    check("R11", v, 8'h00);
    bus_read(8'hF0, v);
    check("R11", v, 8'h00);
    // R1: output registers cleared, visible once group 0 becomes an output
    bus_write(8'hF3, 8'h01);
    bus_read(8'hF0, v);
    check("R1", v, 8'h00);
    bus_read(8'hF7, v);
    check("R1", v, 8'h00);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule